// File: doc/BRIEF.md
# Test-Pattern Sequence Generator

This block produces a diagnostic data stream on one or more parallel streaming outputs. Each word is either an incrementing count or the next state of a maximal-length linear feedback shift register. A small register port runs on its own clock and holds two words: a control word with an enable bit and a pattern-select bit, and a start value for the sequence. Both words can be read back.

Register settings reach the data clock through a toggle handshake: a two-flop synchronizer plus an edge-detect flop. Every register write restarts the sequence from the start value. Each output has a valid/ready pair, and a word counts as delivered only on a cycle where valid and ready are both high. With the broadcast parameter set, a single generator feeds every output. All outputs then carry the same word and advance together, and only when every sink is ready. With broadcast cleared, each output has its own generator, seeded with the start value plus the stream index, and each advances on its own ready.

Top module: `tpg_top`

## Requirements
- R1: After reset, every valid output is low and both register words read back as zero.
- R2: Word address 0 is control: bit 0 enables the block and bit 1 selects the pattern (1 = counter, 0 = pseudo-random). Word address 1 holds the start value. A read returns the addressed word on `regRdData` one register clock after `regRdEn`. Control bits above bit 1 read as zero.
- R3: Within 10 data-clock cycles of a register write, the outputs show the new setting. When enabled, valid is high and the first word equals the start value.
- R4: In counter mode, each accepted word is followed by its value plus one, wrapping modulo 2^SEQ_W.
- R5: In pseudo-random mode, the word after s is {s[SEQ_W-2:0], f}. For the default 32-bit width, f is the XOR of bits 31, 21, 1 and 0. A start value of 0 is replaced by 1.
- R6: While the enable bit is 0, valid stays low and the data word does not change, whatever the ready inputs do. Writing 0 to the control word stops generation.
- R7: While valid is high and ready is low, the data word holds its value.
- R8: With broadcast set, all streams carry the same word on every cycle, and the sequence advances only when every ready input is high.
- R9: Any write to either register word restarts the sequence from the start value, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| regClk | input | 1 | Register port clock |
| regRst | input | 1 | Synchronous active-high reset, register domain |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Word address |
| regWrData | input | SEQ_W | Write data |
| regRdData | output | SEQ_W | Read data, valid one cycle after regRdEn |
| dataClk | input | 1 | Data stream clock |
| dataRst | input | 1 | Synchronous active-high reset, data domain |
| readyIn | input | NUM_STREAMS | Per-stream sink ready |
| validOut | output | NUM_STREAMS | Per-stream valid |
| dataOut | output | NUM_STREAMS*SEQ_W | Stream words, stream 0 in the low bits |

## Verification
The assertions assume the register words are quasi-static: nothing writes them again until the previous write has crossed into the data domain. They also assume the strobes from the data-domain control hold the mode and the start value steady while a load is pending. The stimulus keeps to this by waiting ten data cycles after each write and by holding every ready input low while it reconfigures. Ready is changed only just after a data clock edge, so every sampled handshake is unambiguous.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Strobes from the data-domain control to the datapath
  typedef struct packed {
    logic load;       // reseed generators this cycle
    logic run;        // generation enabled, drives valid
    logic countMode;  // 1 = counter, 0 = pseudo-random
  } tpgStrobe_t;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;

  // Feedback tap mask for a maximal-length shift register of width w
  function automatic logic [63:0] lfsrTaps(input int w);
    case (w)
      8:       return 64'h0000_0000_0000_00B8;
      16:      return 64'h0000_0000_0000_D008;
      24:      return 64'h0000_0000_00E1_0000;
      32:      return 64'h0000_0000_8020_0003;
      64:      return 64'hD800_0000_0000_0000;
      default: return 64'h0000_0000_8020_0003;
    endcase
  endfunction

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs #(
  parameter int SEQ_W  = 32,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEQ_W-1:0]  wrData,
  output logic [SEQ_W-1:0]  rdData,
  output logic [1:0]        ctrlOut,
  output logic [SEQ_W-1:0]  initOut,
  output logic              toggleOut
);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_INIT = ADDR_W'(1);

  logic [1:0]       ctrlQ;
  logic [SEQ_W-1:0] initQ;
  logic             tglQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ  <= '0;
      initQ  <= '0;
      tglQ   <= 1'b0;
      rdData <= '0;
    end else begin
      if (wrEn) begin
        if (addr == ADDR_CTRL) begin
          ctrlQ <= wrData[1:0];
          tglQ  <= ~tglQ;
        end else if (addr == ADDR_INIT) begin
          initQ <= wrData;
          tglQ  <= ~tglQ;
        end
      end
      if (rdEn) begin
        if (addr == ADDR_CTRL)      rdData <= SEQ_W'(ctrlQ);
        else if (addr == ADDR_INIT) rdData <= initQ;
        else                        rdData <= '0;
      end
    end
  end

  assign ctrlOut   = ctrlQ;
  assign initOut   = initQ;
  assign toggleOut = tglQ;

  assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr == ADDR_CTRL) |=> (rdData[SEQ_W-1:2] == '0));

endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int SEQ_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       regCtrl,
  input  logic [SEQ_W-1:0] regInit,
  input  logic             regToggle,
  output tpgStrobe_t       strb,
  output logic [SEQ_W-1:0] seedVal
);

  // two synchronizer flops plus one edge-detect flop
  logic [2:0]       tglPipe;
  logic             cfgEvent;
  logic             enQ;
  logic             modeQ;
  logic             loadQ;
  logic             runQ;
  logic [SEQ_W-1:0] seedQ;

  assign cfgEvent = tglPipe[2] ^ tglPipe[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tglPipe <= '0;
      enQ     <= 1'b0;
      modeQ   <= 1'b0;
      loadQ   <= 1'b0;
      runQ    <= 1'b0;
      seedQ   <= '0;
    end else begin
      tglPipe <= {tglPipe[1:0], regToggle};
      loadQ   <= cfgEvent;
      if (cfgEvent) begin
        // register words are quasi-static here
        enQ   <= regCtrl[CTRL_EN_BIT];
        modeQ <= regCtrl[CTRL_MODE_BIT];
        seedQ <= regInit;
        runQ  <= 1'b0;
      end else if (loadQ) begin
        runQ  <= enQ;
      end
    end
  end

  assign strb.load      = loadQ;
  assign strb.run       = runQ;
  assign strb.countMode = modeQ;
  assign seedVal        = seedQ;

  assert_load_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> !strb.load);

  assert_quiet_on_load_R9: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> !strb.run);

endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  parameter int SEQ_W       = 32,
  parameter int BROADCAST   = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  tpgStrobe_t                   strb,
  input  logic [SEQ_W-1:0]             seedVal,
  input  logic [NUM_STREAMS-1:0]       readyIn,
  output logic [NUM_STREAMS-1:0]       validOut,
  output logic [NUM_STREAMS*SEQ_W-1:0] dataOut
);

  localparam int               NUM_GEN   = (BROADCAST != 0) ? 1 : NUM_STREAMS;
  localparam logic [63:0]      TAPS_FULL = lfsrTaps(SEQ_W);
  localparam logic [SEQ_W-1:0] TAPS      = TAPS_FULL[SEQ_W-1:0];

  logic [SEQ_W-1:0] seqArr [NUM_GEN];

  for (genvar g = 0; g < NUM_GEN; g++) begin : gGen
    logic [SEQ_W-1:0] seqQ;
    logic [SEQ_W-1:0] seedG;
    logic [SEQ_W-1:0] nextVal;
    logic             adv;

    if (BROADCAST != 0) begin : gJoint
      assign adv = strb.run & (&readyIn);
    end else begin : gSolo
      assign adv = strb.run & readyIn[g];
    end

    always_comb begin
      seedG = seedVal + SEQ_W'(g);
      if (!strb.countMode && seedG == '0) seedG = SEQ_W'(1);
    end

    always_comb begin
      if (strb.countMode) nextVal = seqQ + SEQ_W'(1);
      else                nextVal = {seqQ[SEQ_W-2:0], ^(seqQ & TAPS)};
    end

    always_ff @(posedge clk) begin
      if (rst)            seqQ <= '0;
      else if (strb.load) seqQ <= seedG;
      else if (adv)       seqQ <= nextVal;
    end

    assign seqArr[g] = seqQ;

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (strb.run && !adv && !strb.load) |=> $stable(seqQ));

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (!strb.run && !strb.load) |=> $stable(seqQ));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
      (adv && strb.countMode && !strb.load) |=> (seqQ == $past(seqQ) + SEQ_W'(1)));

    assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
      (strb.run && !strb.countMode) |-> (seqQ != '0));
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : gOut
    assign dataOut[s*SEQ_W +: SEQ_W] = seqArr[(BROADCAST != 0) ? 0 : s];
    assign validOut[s]               = strb.run;
  end

endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  parameter int SEQ_W       = 32,
  parameter int BROADCAST   = 1,
  parameter int ADDR_W      = 1
) (
  input  logic                         regClk,
  input  logic                         regRst,
  input  logic                         regWrEn,
  input  logic                         regRdEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [SEQ_W-1:0]             regWrData,
  output logic [SEQ_W-1:0]             regRdData,
  input  logic                         dataClk,
  input  logic                         dataRst,
  input  logic [NUM_STREAMS-1:0]       readyIn,
  output logic [NUM_STREAMS-1:0]       validOut,
  output logic [NUM_STREAMS*SEQ_W-1:0] dataOut
);

  logic [1:0]       ctrlWord;
  logic [SEQ_W-1:0] initWord;
  logic             cfgToggle;
  tpgStrobe_t       strb;
  logic [SEQ_W-1:0] seedVal;

  tpg_regs #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(regClk), .rst(regRst), .wrEn(regWrEn), .rdEn(regRdEn),
    .addr(regAddr), .wrData(regWrData), .rdData(regRdData),
    .ctrlOut(ctrlWord), .initOut(initWord), .toggleOut(cfgToggle)
  );

  tpg_ctrl #(.SEQ_W(SEQ_W)) i_ctrl (
    .clk(dataClk), .rst(dataRst), .regCtrl(ctrlWord), .regInit(initWord),
    .regToggle(cfgToggle), .strb(strb), .seedVal(seedVal)
  );

  tpg_datapath #(.NUM_STREAMS(NUM_STREAMS), .SEQ_W(SEQ_W), .BROADCAST(BROADCAST)) i_dp (
    .clk(dataClk), .rst(dataRst), .strb(strb), .seedVal(seedVal),
    .readyIn(readyIn), .validOut(validOut), .dataOut(dataOut)
  );

endmodule

// File: tb/test_tpg_top.sv
`timescale 1ns/1ps
module test_tpg_top;

  localparam int NS = 2;
  localparam int W  = 32;

  logic          regClk = 1'b0, dataClk = 1'b0;
  logic          regRst = 1'b1, dataRst = 1'b1;
  logic          regWrEn = 1'b0, regRdEn = 1'b0;
  logic [0:0]    regAddr = '0;
  logic [W-1:0]  regWrData = '0;
  logic [W-1:0]  regRdData;
  logic [NS-1:0] readyIn = '0;
  logic [NS-1:0] validOut;
  logic [NS*W-1:0] dataOut;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [W-1:0] expQ[$];
  string curReq = "R4";
  bit monOn = 0;
  bit holdPend = 0;
  logic [W-1:0] holdData;

  tpg_top #(.NUM_STREAMS(NS), .SEQ_W(W), .BROADCAST(1), .ADDR_W(1)) i_tpg_top (
    .regClk(regClk), .regRst(regRst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .dataClk(dataClk), .dataRst(dataRst), .readyIn(readyIn),
    .validOut(validOut), .dataOut(dataOut)
  );

  always #10 dataClk = ~dataClk;
  initial begin #3; forever #10 regClk = ~regClk; end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lfsrStep(input logic [W-1:0] s);
    return {s[W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic regWrite(input int a, input logic [W-1:0] d);
    @(posedge regClk); #1;
    regWrEn = 1'b1; regAddr = a[0:0]; regWrData = d;
    @(posedge regClk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [W-1:0] d);
    @(posedge regClk); #1;
    regRdEn = 1'b1; regAddr = a[0:0];
    @(posedge regClk); #1;
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic settle();
    repeat (10) @(posedge dataClk);
    #1;
  endtask

  // driver: push expected words, then run a ready pattern until all consumed
  task automatic runStream(input bit cnt, input logic [W-1:0] seed, input int n, input string req);
    logic [W-1:0] s;
    int i;
    s = seed;
    if (!cnt && s == '0) s = 1;
    for (int k = 0; k < n; k++) begin
      expQ.push_back(s);
      s = cnt ? s + 1 : lfsrStep(s);
    end
    curReq = req;
    monOn = 1;
    i = 0;
    forever begin
      @(posedge dataClk); #1;
      if (expQ.size() == 0) break;
      if (i % 4 == 1)      readyIn = '0;
      else if (i % 5 == 3) readyIn = 2'b01;
      else if (i % 7 == 5) readyIn = 2'b10;
      else                 readyIn = '1;
      i++;
    end
    readyIn = '0;
    monOn = 0;
  endtask

  // monitor / scoreboard
  always @(negedge dataClk) begin
    if (monOn) begin
      if (holdPend) chk(dataOut[W-1:0] == holdData, "R7", dataOut[W-1:0], holdData);
      chk(dataOut[2*W-1:W] == dataOut[W-1:0], "R8", dataOut[2*W-1:W], dataOut[W-1:0]);
      if (validOut[0] && (&readyIn)) begin
        if (expQ.size() == 0) chk(1'b0, curReq, dataOut[W-1:0], 0);
        else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          chk(dataOut[W-1:0] == e, curReq, dataOut[W-1:0], e);
        end
      end
      holdPend = validOut[0] && !(&readyIn);
      holdData = dataOut[W-1:0];
    end else begin
      holdPend = 0;
    end
  end

  task automatic finishRun();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [W-1:0] rd;
    logic [W-1:0] snap;
    repeat (5) @(posedge dataClk);
    #1; regRst = 0; dataRst = 0;
    settle();

    // R1 reset state
    chk(validOut == '0, "R1", validOut, 0);
    regRead(0, rd); chk(rd == '0, "R1", rd, 0);
    regRead(1, rd); chk(rd == '0, "R1", rd, 0);

    // R2 layout and readback, counter mode
    regWrite(1, 32'd17);
    regWrite(0, 32'h3);
    regRead(0, rd); chk(rd == 32'h3, "R2", rd, 3);
    regRead(1, rd); chk(rd == 32'd17, "R2", rd, 17);
    settle();
    chk(validOut == 2'b11, "R3", validOut, 3);
    chk(dataOut[W-1:0] == 32'd17, "R3", dataOut[W-1:0], 17);
    runStream(1, 32'd17, 40, "R4");

    // R4 wrap
    regWrite(1, 32'hFFFF_FFFE);
    settle();
    chk(dataOut[W-1:0] == 32'hFFFF_FFFE, "R3", dataOut[W-1:0], 32'hFFFF_FFFE);
    runStream(1, 32'hFFFF_FFFE, 4, "R4");

    // R9 restart from start value mid-run
    regWrite(1, 32'd100);
    settle();
    runStream(1, 32'd100, 6, "R9");
    regWrite(0, 32'h3);
    settle();
    chk(dataOut[W-1:0] == 32'd100, "R9", dataOut[W-1:0], 100);
    runStream(1, 32'd100, 3, "R9");

    // R5 pseudo-random
    regWrite(1, 32'd17);
    regWrite(0, 32'h1);
    settle();
    chk(validOut == 2'b11, "R3", validOut, 3);
    runStream(0, 32'd17, 40, "R5");

    // R5 zero seed forced to 1
    regWrite(1, 32'd0);
    settle();
    chk(dataOut[W-1:0] == 32'd1, "R5", dataOut[W-1:0], 1);
    runStream(0, 32'd0, 8, "R5");

    // R6 stop generation
    regWrite(0, 32'h0);
    settle();
    chk(validOut == '0, "R6", validOut, 0);
    snap = dataOut[W-1:0];
    readyIn = '1;
    repeat (6) @(posedge dataClk);
    #1;
    chk(validOut == '0, "R6", validOut, 0);
    chk(dataOut[W-1:0] == snap, "R6", dataOut[W-1:0], snap);
    readyIn = '0;

    // R2 upper control bits read as zero; enable bit clear keeps output off
    regWrite(0, 32'hFFFF_FFF2);
    regRead(0, rd); chk(rd == 32'h2, "R2", rd, 2);
    settle();
    chk(validOut == '0, "R6", validOut, 0);

    finishRun();
  end

endmodule